// File: doc/BRIEF.md
# Write-Only Serial Configuration Port

This block is the register-write front end of a small configuration file of four 8-bit registers. Software on a host writes these registers over one of two serial links. A select input picks the link. The first is an I2C slave that accepts write transfers only. The second is a 3-wire port with a chip select, a clock and a data line, which carries 16-bit frames. Both links write the same registers. The register contents leave the block as one parallel configuration bus.

All pad inputs pass through two-flop synchronisers into a faster system clock, and edges are found on the synchronised copies. The I2C side finds start and stop conditions and matches one slave address, whose lowest bit comes from a strap input. It acknowledges the device byte and then takes a register pointer byte. Each data byte that follows is written and acknowledged, and the pointer then advances. On the 3-wire side a frame is only checked and committed when chip select rises. Neither link can read registers back.

Top module: `ctl_port_top`

## Requirements
- R1: After synchronous reset `cfg_bus` holds register 0 = 0x89, register 1 = 0x02, register 2 = 0x0F and register 3 = 0x00, with register n on bits [8n+7:8n].
- R2: The I2C slave acknowledges (drives `sda_oe` high in the ninth clock) a device byte only when its upper seven bits equal binary 001001 followed by `addr_strap` and its last bit (R/W) is 0. Any other address is not acknowledged, and the rest of that transfer writes nothing.
- R3: A device byte that matches the address with R/W = 1 is not acknowledged, and the transfer writes nothing.
- R4: The byte after an acknowledged device byte loads the register pointer from its low 5 bits, and its upper 3 bits are ignored. Each later data byte is acknowledged and written to the register the pointer names.
- R5: After each I2C data byte the pointer advances by one. From 3 it wraps to 0, so a burst that starts at register 2 writes registers 2, 3, 0, 1, 2 in that order.
- R6: I2C data bytes aimed at pointer values 4 to 31 are acknowledged but change no register.
- R7: A 3-wire frame is 16 bits sampled MSB first on rising edges of `cclk_pad` while `csn_pad` is low. Bits 15:14 are the chip code 11, bit 13 is R/W = 1, bits 12:8 are the register address and bits 7:0 are the data. The register changes only after `csn_pad` rises.
- R8: A 3-wire frame with a chip code other than 11, R/W = 0, or a bit count other than 16 changes no register.
- R9: A write of a value with bit 7 set to register 1, over either link, returns all four registers to their R1 values.
- R10: Register 0 bit 1, register 1 bit 7 and bits 7:4 of registers 2 and 3 always read 0, whatever was written.
- R11: With `mode_i2c` = 1 only the I2C link writes. With `mode_i2c` = 0 only the 3-wire link writes, and `sda_oe` stays low.
- R12: SDA falling while SCL is high starts a new transfer at the device byte, even in the middle of a transfer (repeated start). SDA rising while SCL is high ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i2c | input | 1 | 1 selects the I2C link, 0 selects the 3-wire link |
| addr_strap | input | 1 | Lowest bit of the I2C slave address |
| scl_pad | input | 1 | I2C clock line |
| sda_pad | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the SDA line low (acknowledge) |
| csn_pad | input | 1 | 3-wire chip select, active low |
| cclk_pad | input | 1 | 3-wire serial clock |
| cdti_pad | input | 1 | 3-wire serial data |
| cfg_bus | output | 32 | All four registers side by side, register n on bits [8n+7:8n] |

## Verification
The bench runs pointer bursts that cross the 3-to-0 wrap. A design that wrapped at 31, or advanced the pointer before writing, would put the data into the wrong registers. It sends addresses with the strap bit flipped and addresses with R/W = 1, then checks both the acknowledge slot and that the registers did not change. A slave that acknowledged reads, or ignored the strap, would show up here. It checks the registers after all 16 frame bits have arrived but before chip select rises, which catches a commit that comes too early. It sends frames of 15 and 17 bits and frames with a bad chip code, which catch a port that checks too little. It also writes bit 7 of register 1, runs repeated starts, and drives the inactive link while the other one is selected.

// File: rtl/ctl_port_pkg.sv
// Shared constants and the write-request type for the serial configuration port.
package ctl_port_pkg;
    localparam int NREG = 4;                 // registers in the file
    localparam int DW   = 8;                 // register width
    localparam int AW   = 5;                 // address width on both links
    localparam int BUSW = NREG * DW;         // width of the parallel bus
    localparam int FRW  = 2 + 1 + AW + DW;   // 3-wire frame length

    localparam logic [BUSW-1:0] DEF_BUS  = {8'h00, 8'h0F, 8'h02, 8'h89};
    localparam logic [BUSW-1:0] KEEP_BUS = {8'h0F, 8'h0F, 8'h7F, 8'hFD};
    localparam logic [5:0]      I2C_HI   = 6'b001001;
    localparam logic [1:0]      CHIP     = 2'b11;
    localparam int              RST_REG  = 1;  // register whose bit 7 restores defaults
    localparam int              WRAP_AT  = NREG - 1;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/bit_sync.sv
// Two-flop synchroniser for W independent pad inputs.
// Assumes each input is quasi-static with respect to clk; no glitch filter.
module bit_sync #(
    parameter int          W  = 1,
    parameter logic [W-1:0] RV = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RV;
            q    <= RV;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/i2c_wr_slave.sv
// Write-only I2C slave. Detects start and stop, matches the strapped address,
// acknowledges writes, captures the pointer and issues one write pulse per data byte.
// Assumes synchronised scl/sda and a system clock well above the SCL rate.
module i2c_wr_slave
    import ctl_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    strap,
    input  logic    scl,
    input  logic    sda,
    output logic    sda_oe,
    output wr_req_t wr
);
    typedef enum logic [1:0] {B_DEV, B_PTR, B_DATA} byte_e;

    logic          scl_q, sda_q;
    logic          active, in_ack;
    logic [3:0]    bcnt;
    byte_e         bsel;
    logic [DW-1:0] sh;
    logic [AW-1:0] ptr;
    logic          scl_rise, scl_fall, start_c, stop_c;

    // Previous line levels for edge detection, tracked even while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
    end

    // Transfer sequencer: shift, acknowledge, pointer and write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active <= 1'b0;
            in_ack <= 1'b0;
            bcnt   <= '0;
            bsel   <= B_DEV;
            sh     <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_c) begin
                active <= 1'b1;
                in_ack <= 1'b0;
                bcnt   <= '0;
                bsel   <= B_DEV;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                active <= 1'b0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (active) begin
                if (scl_rise && !in_ack && bcnt != 4'd8) begin
                    sh   <= {sh[DW-2:0], sda};
                    bcnt <= bcnt + 4'd1;
                end
                if (scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        sda_oe <= 1'b0;
                    end else if (bcnt == 4'd8) begin
                        bcnt <= '0;
                        case (bsel)
                            B_DEV: begin
                                if (sh[7:1] == {I2C_HI, strap} && !sh[0]) begin
                                    in_ack <= 1'b1;
                                    sda_oe <= 1'b1;
                                    bsel   <= B_PTR;
                                end else begin
                                    active <= 1'b0;
                                end
                            end
                            B_PTR: begin
                                ptr    <= sh[AW-1:0];
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                                bsel   <= B_DATA;
                            end
                            default: begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= sh;
                                ptr     <= (ptr == AW'(WRAP_AT)) ? '0 : ptr + 1'b1;
                                in_ack  <= 1'b1;
                                sda_oe  <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wire3_wr_rx.sv
// 3-wire frame receiver. Shifts bits on cclk rising while csn is low and
// validates and commits the frame on csn rising.
// Assumes synchronised inputs and a system clock well above the cclk rate.
module wire3_wr_rx
    import ctl_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    csn,
    input  logic    cclk,
    input  logic    cdti,
    output wr_req_t wr
);
    localparam int CW = $clog2(FRW + 2);

    logic           csn_q, cclk_q;
    logic [FRW-1:0] sh;
    logic [CW-1:0]  cnt;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            cclk_q <= 1'b1;
        end else begin
            csn_q  <= csn;
            cclk_q <= cclk;
        end
    end

    // Frame capture with bit count saturating one above the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh  <= '0;
            cnt <= '0;
            wr  <= '0;
        end else begin
            wr.en <= 1'b0;
            if (!csn && csn_q) begin
                cnt <= '0;
            end else if (!csn && cclk && !cclk_q) begin
                if (cnt < CW'(FRW)) sh <= {sh[FRW-2:0], cdti};
                if (cnt != CW'(FRW + 1)) cnt <= cnt + 1'b1;
            end else if (csn && !csn_q) begin
                if (cnt == CW'(FRW) && sh[FRW-1 -: 2] == CHIP && sh[FRW-3]) begin
                    wr.en   <= 1'b1;
                    wr.addr <= sh[DW +: AW];
                    wr.data <= sh[DW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/ctl_regfile.sv
// Four-register configuration file with per-bit write masks and a
// restore-all-defaults command through bit 7 of register 1.
module ctl_regfile
    import ctl_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  wr_req_t         wr,
    output logic [BUSW-1:0] cfg
);
    logic restore;

    // Restore command: write with bit 7 set to the restore register.
    assign restore = wr.en && wr.addr == AW'(RST_REG) && wr.data[7];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] r;
        // Register i: defaults on reset or restore, masked write otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n || restore) r <= DEF_BUS[i*DW +: DW];
            else if (wr.en && wr.addr == AW'(i)) r <= wr.data & KEEP_BUS[i*DW +: DW];
        end
        assign cfg[i*DW +: DW] = r;
    end
endmodule

// File: rtl/ctl_port_top.sv
// Serial configuration port top. Synchronises pads, runs both link receivers,
// selects the active link's write requests and holds the register file.
// Assumes mode_i2c changes only while both links are idle.
module ctl_port_top
    import ctl_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_i2c,
    input  logic        addr_strap,
    input  logic        scl_pad,
    input  logic        sda_pad,
    output logic        sda_oe,
    input  logic        csn_pad,
    input  logic        cclk_pad,
    input  logic        cdti_pad,
    output logic [31:0] cfg_bus
);
    logic [1:0] i2c_s;
    logic [2:0] w3_s;
    wr_req_t    wr_i2c, wr_w3, wr_sel;
    logic       wr_en;
    logic [AW-1:0] wr_addr;

    bit_sync #(.W(2), .RV(2'b11)) u_sync_i2c (
        .clk(clk), .rst_n(rst_n), .d({scl_pad, sda_pad}), .q(i2c_s));

    bit_sync #(.W(3), .RV(3'b111)) u_sync_w3 (
        .clk(clk), .rst_n(rst_n), .d({csn_pad, cclk_pad, cdti_pad}), .q(w3_s));

    i2c_wr_slave u_i2c (
        .clk(clk), .rst_n(rst_n), .en(mode_i2c), .strap(addr_strap),
        .scl(i2c_s[1]), .sda(i2c_s[0]), .sda_oe(sda_oe), .wr(wr_i2c));

    wire3_wr_rx u_w3 (
        .clk(clk), .rst_n(rst_n), .en(!mode_i2c),
        .csn(w3_s[2]), .cclk(w3_s[1]), .cdti(w3_s[0]), .wr(wr_w3));

    // Only the selected link reaches the register file.
    assign wr_sel  = mode_i2c ? wr_i2c : wr_w3;
    assign wr_en   = wr_sel.en;
    assign wr_addr = wr_sel.addr;

    ctl_regfile u_rf (.clk(clk), .rst_n(rst_n), .wr(wr_sel), .cfg(cfg_bus));
endmodule

// File: rtl/ctl_port_chk.sv
// Property checker for ctl_port_top, attached through bind.
module ctl_port_chk
    import ctl_port_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            mode_i2c,
    input logic            sda_oe,
    input logic [31:0]     cfg_bus,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr
);
    logic was_rst = 1'b0;

    // Remembers that the previous cycle was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> cfg_bus == DEF_BUS); // R1
    AST_MASKED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bus & ~KEEP_BUS) == '0); // R10
    AST_HIGH_ADDR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr >= AW'(NREG) |=> $stable(cfg_bus)); // R6
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_bus)); // R8
    AST_SDA_QUIET_3W: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i2c && !$past(mode_i2c) |-> !sda_oe); // R11
endmodule

bind ctl_port_top ctl_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i2c(mode_i2c), .sda_oe(sda_oe),
    .cfg_bus(cfg_bus), .wr_en(wr_en), .wr_addr(wr_addr));

// File: tb/ctl_port_top_bench.sv
// Self-checking bench for ctl_port_top: directed corners plus seeded random traffic.
module ctl_port_top_bench;
    localparam int W = 6;   // system clocks per serial half-phase

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_i2c = 1'b1, addr_strap = 1'b0;
    logic scl = 1'b1, sda_drv = 1'b1;
    logic csn = 1'b1, cclk = 1'b1, cdti = 1'b1;
    logic sda_oe, sda_line;
    logic [31:0] cfg_bus;
    int checks = 0, fails = 0;
    logic [7:0] m [4];
    logic [7:0] dbuf [8];

    always #2.5 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    ctl_port_top u_ctl_port_top (
        .clk(clk), .rst_n(rst_n), .mode_i2c(mode_i2c), .addr_strap(addr_strap),
        .scl_pad(scl), .sda_pad(sda_line), .sda_oe(sda_oe),
        .csn_pad(csn), .cclk_pad(cclk), .cdti_pad(cdti), .cfg_bus(cfg_bus));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] keep(input int i);
        case (i)
            0: keep = 8'hFD;
            1: keep = 8'h7F;
            default: keep = 8'h0F;
        endcase
    endfunction

    task automatic model_defaults();
        m[0] = 8'h89; m[1] = 8'h02; m[2] = 8'h0F; m[3] = 8'h00;
    endtask

    task automatic model_wr(input int a, input logic [7:0] d);
        if (a == 1 && d[7]) model_defaults();
        else if (a < 4) m[a] = d & keep(a);
    endtask

    function automatic logic [31:0] exp_bus();
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; tick(W); scl = 1'b1; tick(W);
        sda_drv = 1'b0; tick(W); scl = 1'b0; tick(W);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; tick(W); scl = 1'b1; tick(W);
        sda_drv = 1'b1; tick(W);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(W); scl = 1'b1; tick(W); scl = 1'b0; tick(W);
        end
        sda_drv = 1'b1; tick(W); scl = 1'b1; tick(W/2);
        ack = !sda_line;
        tick(W - W/2); scl = 1'b0; tick(W);
    endtask

    // Full transfer: device byte, pointer, n data bytes from dbuf, stop.
    task automatic i2c_xfer(input string req, input logic [6:0] dev, input logic rw,
                            input logic [7:0] sub, input int n);
        logic ack, exp_ack;
        int p;
        exp_ack = (dev == {6'b001001, addr_strap}) && !rw;
        i2c_start();
        i2c_byte({dev, rw}, ack);
        check({req, " dev ack"}, {31'd0, ack}, {31'd0, exp_ack});
        i2c_byte(sub, ack);
        if (exp_ack) check({req, " ptr ack"}, {31'd0, ack}, 32'd1);
        p = int'(sub[4:0]);
        for (int k = 0; k < n; k++) begin
            i2c_byte(dbuf[k], ack);
            if (exp_ack) begin
                check({req, " data ack"}, {31'd0, ack}, 32'd1);
                model_wr(p, dbuf[k]);
                p = (p == 3) ? 0 : (p + 1) % 32;
            end
        end
        i2c_stop();
        tick(4);
        check({req, " regs"}, cfg_bus, exp_bus());
    endtask

    // Sends the first nb bits of f, MSB first; leaves chip select low.
    task automatic w3_bits(input logic [15:0] f, input int nb);
        csn = 1'b0; tick(W);
        for (int i = 0; i < nb; i++) begin
            cclk = 1'b0; cdti = (i < 16) ? f[15 - i] : 1'b1; tick(W);
            cclk = 1'b1; tick(W);
        end
    endtask

    task automatic w3_frame(input string req, input logic [15:0] f, input int nb);
        w3_bits(f, nb);
        csn = 1'b1; tick(W);
        if (nb == 16 && f[15:13] == 3'b111) model_wr(int'(f[12:8]), f[7:0]);
        check({req, " regs"}, cfg_bus, exp_bus());
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] a;
        int n;
        void'($urandom(32'd20240611));
        model_defaults();
        tick(4); rst_n = 1'b1; tick(2);
        check("R1 reset defaults", cfg_bus, 32'h000F0289);
        check("R1 sda idle", {31'd0, sda_oe}, 32'd0);

        // R4 R10: all ones to register 0 keeps bit 1 clear
        dbuf[0] = 8'hFF;
        i2c_xfer("R4 R10 write reg0", 7'b0010010, 1'b0, 8'h00, 1);
        // R2: strap mismatch is not acknowledged
        dbuf[0] = 8'h11;
        i2c_xfer("R2 wrong address", 7'b0010011, 1'b0, 8'h02, 1);
        // R3: read request is not acknowledged
        i2c_xfer("R3 read refused", 7'b0010010, 1'b1, 8'h02, 1);
        // R5: burst from 2 wraps through 3 to 0
        dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h12; dbuf[3] = 8'h55; dbuf[4] = 8'h07;
        i2c_xfer("R5 wrap burst", 7'b0010010, 1'b0, 8'h02, 5);
        check("R5 wrap content", cfg_bus, {8'h0C, 8'h07, 8'h55, 8'h10});
        // R6: high address acknowledged and discarded
        dbuf[0] = 8'h66; dbuf[1] = 8'h77;
        i2c_xfer("R6 high addr", 7'b0010010, 1'b0, 8'h05, 2);
        // R4: upper pointer bits ignored
        dbuf[0] = 8'h33;
        i2c_xfer("R4 ptr upper bits", 7'b0010010, 1'b0, 8'hE1, 1);
        // R9: bit 7 to register 1 restores defaults
        dbuf[0] = 8'h80;
        i2c_xfer("R9 restore i2c", 7'b0010010, 1'b0, 8'h01, 1);
        check("R9 defaults back", cfg_bus, 32'h000F0289);

        // R12: repeated start mid-transfer restarts at the device byte
        i2c_start();
        i2c_byte(8'h24, ack); i2c_byte(8'h00, ack); i2c_byte(8'h41, ack);
        model_wr(0, 8'h41);
        i2c_start();
        i2c_byte(8'h24, ack);
        check("R12 restart dev ack", {31'd0, ack}, 32'd1);
        i2c_byte(8'h03, ack); i2c_byte(8'h09, ack);
        model_wr(3, 8'h09);
        i2c_stop(); tick(4);
        check("R12 restart regs", cfg_bus, exp_bus());

        // R2: strap high moves the address
        addr_strap = 1'b1; tick(4);
        dbuf[0] = 8'h0A;
        i2c_xfer("R2 strap high", 7'b0010011, 1'b0, 8'h02, 1);
        dbuf[0] = 8'h0B;
        i2c_xfer("R2 strap high old addr", 7'b0010010, 1'b0, 8'h02, 1);

        // R11: 3-wire frame ignored while I2C selected
        w3_bits(16'hE155, 16); csn = 1'b1; tick(W);
        check("R11 3w ignored in i2c mode", cfg_bus, exp_bus());

        mode_i2c = 1'b0; tick(8);
        // R7: no commit before chip select rises, commit after
        w3_bits(16'hE03C, 16); tick(W);
        check("R7 before csn rise", cfg_bus, exp_bus());
        csn = 1'b1; tick(W);
        model_wr(0, 8'h3C);
        check("R7 after csn rise", cfg_bus, exp_bus());
        w3_frame("R7 reg2", 16'hE2F6, 16);
        // R8: bad code, R/W zero, short and long frames
        w3_frame("R8 bad chip code", 16'hA3AA, 16);
        w3_frame("R8 rw zero", 16'hC3AA, 16);
        w3_frame("R8 short frame", 16'hE3AA, 15);
        w3_frame("R8 long frame", 16'hE3AA, 17);
        w3_frame("R6 3w high addr", 16'hE7AA, 16);
        w3_frame("R9 restore 3w", 16'hE181, 16);
        check("R9 3w defaults", cfg_bus, 32'h000F0289);
        // R11: I2C write ignored and SDA never driven
        i2c_start(); i2c_byte(8'h26, ack);
        check("R11 no ack in 3w mode", {31'd0, ack}, 32'd0);
        i2c_byte(8'h00, ack); i2c_byte(8'h44, ack); i2c_stop(); tick(4);
        check("R11 i2c ignored in 3w mode", cfg_bus, exp_bus());

        // Random traffic on both links
        for (int it = 0; it < 40; it++) begin
            if (it % 2 == 0) begin
                mode_i2c = 1'b1; tick(8);
                n = 1 + $urandom_range(0, 5);
                for (int k = 0; k < 8; k++) begin
                    dbuf[k] = 8'($urandom);
                    if ($urandom_range(0, 3) != 0) dbuf[k][7] = 1'b0;
                end
                a = 8'($urandom_range(0, 6));
                i2c_xfer("R5 random i2c", ($urandom_range(0, 7) == 0) ? 7'b0010010 : 7'b0010011,
                         ($urandom_range(0, 7) == 0), a, n);
            end else begin
                mode_i2c = 1'b0; tick(8);
                w3_frame("R7 random 3w",
                         {($urandom_range(0, 5) == 0) ? 3'b101 : 3'b111,
                          5'($urandom_range(0, 5)), 8'($urandom) & 8'h7F},
                         ($urandom_range(0, 7) == 0) ? 15 : 16);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule